// File: doc/BRIEF.md
# Supply Trip-Point Adjustment Command Detector

This block sits beside a serial peripheral port and watches its traffic for a fixed unlock sequence that retunes a supply-monitor trip threshold. It listens only while a separate program-enable input is high. The sequence is made of two chip-select frames. The final byte of the second frame selects one of two operations. The first raises the threshold to the supply level present at that moment. The second returns the threshold to its native low value. When a valid sequence ends, the block issues a one-cycle request to the analog trim logic. It then holds off further adjustments through a self-timed program window and a recovery window.

The serial inputs (`sck`, `sdi`, `csn`) and `prog_en` must already be synchronous to `clk` and must stay stable for at least two `clk` cycles per level. The block finds edges by comparing each input with its value one cycle earlier. Data bits are taken on rising `sck` edges while `csn` is low, most significant bit first. A frame ends on the rising edge of `csn`.

Top module: `trip_prog_detect`

## Requirements
- R1: A first frame of exactly 24 bits equal to 0x030001 (bytes 03h, 00h, 01h, MSB first, bits sampled on rising `sck` while `csn` is low) arms the detector when `csn` rises, provided `prog_en` is high.
- R2: Once the detector is armed, a second frame of exactly 24 bits equal to 0x020001 makes `set_req` high for exactly one cycle, in the cycle after the rising `csn` edge is sampled.
- R3: Once the detector is armed, a second frame of exactly 24 bits equal to 0x020003 makes `clr_req` high for exactly one cycle, with the same timing as R2.
- R4: Either frame with the wrong bit count or the wrong content produces no request and sends the detector back to idle. A correct second frame sent after that produces no request.
- R5: If `prog_en` is low at any point during a sequence, no request is issued. This includes `prog_en` falling in the same cycle as the closing `csn` rise.
- R6: `busy` goes high in the cycle of the request and stays high for exactly BUSY_CYCLES cycles. `recovering` then stays high for exactly RECOV_CYCLES cycles. The two are never high together.
- R7: `done` pulses for one cycle when the program window ends. If `prog_en` falls during the program window, the window ends at once with `done`, and the detector returns directly to idle with no recovery window.
- R8: Any sequence that arrives during the program window or the recovery window is ignored.
- R9: After reset all outputs are low and the detector is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock; data is sampled on its rising edge |
| sdi | input | 1 | Serial data in |
| csn | input | 1 | Active-low chip select; a frame ends on its rising edge |
| prog_en | input | 1 | Program enable; commands are accepted only while it is high |
| set_req | output | 1 | One-cycle request to raise the threshold to the present supply |
| clr_req | output | 1 | One-cycle request to restore the native threshold |
| busy | output | 1 | Program window in progress |
| recovering | output | 1 | Recovery window in progress |
| done | output | 1 | One-cycle pulse when the program window ends |

## Verification
Two events can land in the same clock cycle: the closing rise of `csn` on the second frame, which would issue a request, and the fall of `prog_en`, which must cancel the sequence. The bench drives both on the same falling clock edge at the end of an otherwise correct set sequence, and expects no request and no `busy`. A second collision happens in the program window, where a drop of `prog_en` competes with the busy timer. The bench checks that this produces a single `done` pulse, that no recovery window follows, and that a new sequence sent right afterwards is accepted.

// File: rtl/trip_prog_detect.sv
module trip_prog_detect #(
  parameter int BUSY_CYCLES  = 1250000,
  parameter int RECOV_CYCLES = 1250000,
  parameter int FRAME_BITS   = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic sdi,
  input  logic csn,
  input  logic prog_en,
  output logic set_req,
  output logic clr_req,
  output logic busy,
  output logic recovering,
  output logic done
);
  localparam int MAXT = (BUSY_CYCLES > RECOV_CYCLES) ? BUSY_CYCLES : RECOV_CYCLES;
  localparam int TW   = $clog2(MAXT + 1);
  localparam int CW   = $clog2(FRAME_BITS + 2);
  localparam logic [TW-1:0] BUSY_LAST  = TW'(BUSY_CYCLES - 1);
  localparam logic [TW-1:0] RECOV_LAST = TW'(RECOV_CYCLES - 1);
  localparam logic [CW-1:0] FULL = CW'(FRAME_BITS);
  localparam logic [CW-1:0] SAT  = CW'(FRAME_BITS + 1);
  localparam logic [FRAME_BITS-1:0] UNLOCK = FRAME_BITS'(24'h030001);
  localparam logic [FRAME_BITS-1:0] RAISE  = FRAME_BITS'(24'h020001);
  localparam logic [FRAME_BITS-1:0] NATIVE = FRAME_BITS'(24'h020003);

  typedef enum logic [1:0] {IDLE, ARMED, PROG, RECOV} st_t;
  st_t state;

  logic                  csn_q, sck_q;
  logic [FRAME_BITS-1:0] shreg;
  logic [CW-1:0]         cnt;
  logic [TW-1:0]         tmr;

  wire cs_rise  = csn & ~csn_q;
  wire cs_fall  = ~csn & csn_q;
  wire sck_rise = sck & ~sck_q;
  wire full     = (cnt == FULL);

  assign busy       = (state == PROG);
  assign recovering = (state == RECOV);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= IDLE;
      csn_q   <= 1'b1;
      sck_q   <= 1'b0;
      shreg   <= '0;
      cnt     <= '0;
      tmr     <= '0;
      set_req <= 1'b0;
      clr_req <= 1'b0;
      done    <= 1'b0;
    end else begin
      csn_q   <= csn;
      sck_q   <= sck;
      set_req <= 1'b0;
      clr_req <= 1'b0;
      done    <= 1'b0;

      if (cs_fall) begin
        cnt   <= '0;
        shreg <= '0;
      end else if (sck_rise && !csn) begin
        shreg <= {shreg[FRAME_BITS-2:0], sdi};
        if (cnt != SAT) cnt <= cnt + 1'b1;
      end
      if (!prog_en) cnt <= SAT;

      case (state)
        IDLE, ARMED: begin
          if (!prog_en) state <= IDLE;
          else if (cs_rise) begin
            if (state == IDLE) state <= (full && shreg == UNLOCK) ? ARMED : IDLE;
            else if (full && shreg == RAISE) begin
              set_req <= 1'b1; state <= PROG; tmr <= '0;
            end else if (full && shreg == NATIVE) begin
              clr_req <= 1'b1; state <= PROG; tmr <= '0;
            end else state <= IDLE;
          end
        end
        PROG: begin
          if (!prog_en) begin
            done <= 1'b1; state <= IDLE;
          end else if (tmr == BUSY_LAST) begin
            done <= 1'b1; state <= RECOV; tmr <= '0;
          end else tmr <= tmr + 1'b1;
        end
        default: begin
          if (tmr == RECOV_LAST) state <= IDLE;
          else tmr <= tmr + 1'b1;
        end
      endcase
    end
  end

  assert_req_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_req && clr_req));
  assert_req_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (set_req || clr_req) |-> busy);
  assert_busy_origin_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (set_req || clr_req));
  assert_windows_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && recovering));
  assert_req_enabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (set_req || clr_req) |-> $past(prog_en));
  assert_done_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_timer_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (tmr <= BUSY_LAST));
endmodule

// File: tb/trip_prog_detect_test.sv
module trip_prog_detect_test;
  localparam int BUSY  = 800;
  localparam int RECOV = 800;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, sdi = 1'b0, csn = 1'b1, prog_en = 1'b0;
  logic set_req, clr_req, busy, recovering, done;

  trip_prog_detect #(.BUSY_CYCLES(BUSY), .RECOV_CYCLES(RECOV)) uut (
    .clk(clk), .rst_n(rst_n), .sck(sck), .sdi(sdi), .csn(csn), .prog_en(prog_en),
    .set_req(set_req), .clr_req(clr_req), .busy(busy), .recovering(recovering), .done(done));

  always #4 clk = ~clk;

  int checks = 0, failures = 0, cyc = 0;
  int set_n, clr_n, busy_n, rec_n, done_n;
  logic zap = 1'b0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (zap) begin
      set_n <= 0; clr_n <= 0; busy_n <= 0; rec_n <= 0; done_n <= 0;
    end else begin
      set_n  <= set_n + int'(set_req);
      clr_n  <= clr_n + int'(clr_req);
      busy_n <= busy_n + int'(busy);
      rec_n  <= rec_n + int'(recovering);
      done_n <= done_n + int'(done);
    end
  end

  always @(posedge clk) if (cyc > 150000) begin
    failures = failures + 1;
    $display("FAIL watchdog expired actual=%0d expected<=150000", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
    $finish;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_counts();
    @(negedge clk); zap = 1'b1;
    @(negedge clk); zap = 1'b0;
  endtask

  task automatic frame(input logic [31:0] d, input int n, input int glitch_at, input bit drop_end);
    @(negedge clk); csn = 1'b0; ticks(2);
    for (int i = 0; i < n; i++) begin
      sdi = d[n-1-i]; ticks(2);
      sck = 1'b1;
      if (i == glitch_at) prog_en = 1'b0;
      ticks(2);
      sck = 1'b0;
      if (i == glitch_at) prog_en = 1'b1;
      ticks(2);
    end
    csn = 1'b1;
    if (drop_end) prog_en = 1'b0;
    ticks(3);
  endtask

  localparam int NV = 7;
  localparam logic [31:0] F1 [NV] = '{32'h030001, 32'h030001, 32'h030002, 32'h030001,
                                      32'h030001, 32'h03000100, 32'h030001};
  localparam int N1 [NV] = '{24, 24, 24, 24, 24, 32, 24};
  localparam logic [31:0] F2 [NV] = '{32'h020001, 32'h020003, 32'h020001, 32'h020002,
                                      32'h0200, 32'h020001, 32'h020001};
  localparam int N2 [NV] = '{24, 24, 24, 24, 16, 24, 24};
  localparam logic PE [NV] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0};
  localparam int XS [NV] = '{1, 0, 0, 0, 0, 0, 0};
  localparam int XC [NV] = '{0, 1, 0, 0, 0, 0, 0};
  localparam string TAG [NV] = '{"R2 set", "R3 restore", "R4 bad first", "R4 bad second",
                                 "R4 short second", "R4 long first", "R5 disabled"};

  initial begin
    ticks(3);
    check("R9 set_req at reset", int'(set_req), 0);
    check("R9 clr_req at reset", int'(clr_req), 0);
    check("R9 busy at reset", int'(busy), 0);
    check("R9 recovering/done at reset", int'(recovering | done), 0);
    rst_n = 1'b1;
    ticks(2);

    for (int v = 0; v < NV; v++) begin
      clear_counts();
      prog_en = PE[v];
      frame(F1[v], N1[v], -1, 1'b0);
      frame(F2[v], N2[v], -1, 1'b0);
      ticks(BUSY + RECOV + 10);
      check({TAG[v], " set count"}, set_n, XS[v]);
      check({TAG[v], " clr count"}, clr_n, XC[v]);
    end

    // R1 R2 R6 R7: exact window lengths on a full sequence
    prog_en = 1'b1;
    clear_counts();
    frame(32'h030001, 24, -1, 1'b0);
    frame(32'h020001, 24, -1, 1'b0);
    check("R2 busy right after request", int'(busy), 1);
    ticks(BUSY + RECOV + 10);
    check("R6 busy length", busy_n, BUSY);
    check("R6 recovery length", rec_n, RECOV);
    check("R7 one done pulse", done_n, 1);

    // R8: traffic during busy and during recovery is ignored
    clear_counts();
    frame(32'h030001, 24, -1, 1'b0);
    frame(32'h020001, 24, -1, 1'b0);
    frame(32'h030001, 24, -1, 1'b0);
    frame(32'h020003, 24, -1, 1'b0);
    wait (recovering == 1'b1);
    frame(32'h030001, 24, -1, 1'b0);
    frame(32'h020003, 24, -1, 1'b0);
    check("R8 still recovering", int'(recovering), 1);
    wait (recovering == 1'b0);
    ticks(5);
    check("R8 ignored in windows", clr_n, 0);
    check("R8 only first accepted", set_n, 1);

    // R7: enable drop during program window
    clear_counts();
    frame(32'h030001, 24, -1, 1'b0);
    frame(32'h020001, 24, -1, 1'b0);
    ticks(100);
    prog_en = 1'b0;
    ticks(3);
    check("R7 done on enable drop", done_n, 1);
    check("R7 no recovery after drop", int'(busy | recovering), 0);
    prog_en = 1'b1;
    ticks(2);
    frame(32'h030001, 24, -1, 1'b0);
    frame(32'h020003, 24, -1, 1'b0);
    check("R7 idle again, accepted", clr_n, 1);
    ticks(BUSY + RECOV + 10);

    // R5: enable falls in the same cycle as the closing chip-select rise
    clear_counts();
    frame(32'h030001, 24, -1, 1'b0);
    frame(32'h020001, 24, -1, 1'b1);
    ticks(5);
    check("R5 simultaneous drop", set_n + int'(busy), 0);
    prog_en = 1'b1;
    ticks(2);

    // R5: glitch of enable in the middle of the first frame
    clear_counts();
    frame(32'h030001, 24, 10, 1'b0);
    frame(32'h020001, 24, -1, 1'b0);
    ticks(5);
    check("R5 mid-frame glitch", set_n, 0);

    // R4: a bad second frame disarms; a later good second frame alone does nothing
    clear_counts();
    frame(32'h030001, 24, -1, 1'b0);
    frame(32'h020007, 24, -1, 1'b0);
    frame(32'h020001, 24, -1, 1'b0);
    ticks(5);
    check("R4 disarmed after bad frame", set_n, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule